// File: doc/BRIEF.md
# Four-Lane Dual-Width Data FIFO

This block buffers bytes between a host register port and a byte-serial shift engine. Its storage is four byte-wide lanes, each 16 entries deep. A 32-bit host access moves one byte into or out of every lane in the same cycle, so a word-mode buffer holds 64 bytes. An 8-bit host access touches lane 0 only, so a byte-mode buffer holds 16 bytes. The shift engine moves one byte per request. In word mode it walks the lanes 0, 1, 2, 3 and then wraps. In byte mode it stays on lane 0.

Two instances are used. In the transmit instance the host writes and the engine pops. In the receive instance the engine pushes and the host reads. Status flags follow the current fill level and are combinational, so a flag that software has dealt with is still high on the next look if its condition still holds. A request that cannot be served is discarded and raises a one-cycle error pulse. The host access width is taken from the first host request seen while the buffer is unlocked, and it holds until a pop empties the buffer. A soft reset clears everything.

Top module: `quad_lane_fifo`

## Requirements
- R1: On a 32-bit write, bits [7:0] go to lane 0, [15:8] to lane 1, [23:16] to lane 2 and [31:24] to lane 3. The engine then pops bytes in lane order 0, 1, 2, 3, wrapping, so bytes leave lowest byte first and words leave in write order.
- R2: In word mode the buffer accepts 16 words (64 bytes) and full_o then rises. A further 32-bit write is discarded, illegal_o is high in the following cycle, and all 64 stored bytes still leave in order.
- R3: In byte mode only lane 0 is used. full_o rises after 16 bytes, a 17th 8-bit write is discarded with illegal_o, and bytes leave in write order.
- R4: In word mode each engine push goes to the next lane in the order 0, 1, 2, 3. word_avail_o is high only while every lane holds a byte. A 32-bit read returns the first pushed byte in bits [7:0].
- R5: byte_avail_o is high only in byte mode while lane 0 holds data. 8-bit reads return bytes in push order.
- R6: empty_o (fill 0), half_o (fill at least half the mode capacity), full_o (fill equals the mode capacity) and low_water_o (fill at most LOW_MARK bytes) follow the current fill level in the same cycle, with no stored state.
- R7: A read or engine pop with no data is discarded, changes no stored state, and gives illegal_o high in the next cycle.
- R8: The first host access on an unlocked buffer fixes the host width. An access of the other width is discarded with illegal_o until a pop empties the buffer. After that, the other width is accepted.
- R9: soft_rst_i empties all lanes, returns every lane pointer to lane 0, unlocks the mode and clears illegal_o.
- R10: An engine push and a host write in the same cycle: the engine byte is stored and the host write is discarded with illegal_o. The same rule applies to an engine pop and a host read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of all lanes, pointers, mode and flags |
| wr32_i | input | 1 | Host 32-bit write request |
| wr32_data_i | input | 32 | Host write word |
| wr8_i | input | 1 | Host 8-bit write request |
| wr8_data_i | input | 8 | Host write byte |
| rd32_i | input | 1 | Host 32-bit read request |
| rd32_data_o | output | 32 | Head word, lane 0 in bits [7:0] |
| rd8_i | input | 1 | Host 8-bit read request |
| rd8_data_o | output | 8 | Head byte of lane 0 |
| eng_push_i | input | 1 | Engine byte push request |
| eng_push_data_i | input | 8 | Engine byte to store |
| eng_pop_i | input | 1 | Engine byte pop request |
| eng_pop_data_o | output | 8 | Head byte of the engine's current lane |
| full_o | output | 1 | Fill equals mode capacity |
| half_o | output | 1 | Fill at least half of mode capacity |
| empty_o | output | 1 | No data stored |
| low_water_o | output | 1 | Fill at most LOW_MARK bytes |
| word_avail_o | output | 1 | Word mode and every lane holds a byte |
| byte_avail_o | output | 1 | Byte mode and lane 0 holds a byte |
| illegal_o | output | 1 | A request was discarded in the previous cycle |

## Verification
The transmit path is run with words whose four bytes all differ, so a swapped lane or a wrong engine rotation shows up as a wrong byte position. Filling to 64 bytes and to 16 bytes separates the two capacities, and the overflow write that follows shows whether the pointers survive a rejected request. The receive path is run with pushes that are not a multiple of four, which shows whether word availability waits for all four lanes. Width switches, same-cycle engine and host collisions, and a soft reset in the middle of a rotation check that the mode lock and the lane pointers start over cleanly.

// File: rtl/qlf_pkg.sv
package qlf_pkg;
  typedef enum logic {
    MODE_WORD = 1'b0,
    MODE_BYTE = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/qlf_lane.sv
module qlf_lane #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= step(wp_q);
      if (pop_i)  rp_q <= step(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o = mem[rp_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/qlf_ctrl.sv
module qlf_ctrl
  import qlf_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        soft_rst_i,
  input  logic                        wr32_i,
  input  logic                        wr8_i,
  input  logic                        rd32_i,
  input  logic                        rd8_i,
  input  logic                        eng_push_i,
  input  logic                        eng_pop_i,
  input  logic [LANES-1:0][CNT_W-1:0] cnt_i,
  output logic [LANES-1:0]            push_o,
  output logic [LANES-1:0]            pop_o,
  output logic                        eng_push_ok_o,
  output logic                        host_word_ok_o,
  output logic [LANE_W-1:0]           pop_lane_o,
  output acc_mode_e                   mode_o,
  output logic                        illegal_o
);
  logic              locked_q, ill_q;
  acc_mode_e         mode_q, eff_mode;
  logic [LANE_W-1:0] wl_q, rl_q, ep_lane, eo_lane;
  logic [LANES-1:0]  room, have, nxt_zero;
  logic              host_any, g_w32, g_w8, g_r32, g_r8, g_epush, g_epop, bad, drain;

  function automatic logic [LANE_W-1:0] nxt(input logic [LANE_W-1:0] l);
    return (l == LANE_W'(LANES - 1)) ? '0 : l + 1'b1;
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign room[l] = cnt_i[l] != CNT_W'(DEPTH);
    assign have[l] = cnt_i[l] != '0;
    assign push_o[l] = g_w32 | (g_w8 && (l == 0)) | (g_epush && (ep_lane == LANE_W'(l)));
    assign pop_o[l]  = g_r32 | (g_r8 && (l == 0)) | (g_epop && (eo_lane == LANE_W'(l)));
    assign nxt_zero[l] = (cnt_i[l] == '0 && !push_o[l]) ||
                         (cnt_i[l] == CNT_W'(1) && pop_o[l] && !push_o[l]);
  end

  assign host_any = wr32_i | wr8_i | rd32_i | rd8_i;

  always_comb begin
    if (locked_q)              eff_mode = mode_q;
    else if (wr32_i || rd32_i) eff_mode = MODE_WORD;
    else if (wr8_i || rd8_i)   eff_mode = MODE_BYTE;
    else                       eff_mode = MODE_WORD;
  end

  assign ep_lane = (eff_mode == MODE_WORD) ? wl_q : '0;
  assign eo_lane = (eff_mode == MODE_WORD) ? rl_q : '0;

  // engine side wins over host side within a direction
  assign g_epush = eng_push_i && room[ep_lane];
  assign g_w32   = wr32_i && !eng_push_i && eff_mode == MODE_WORD && (&room);
  assign g_w8    = wr8_i && !eng_push_i && !wr32_i && eff_mode == MODE_BYTE && room[0];
  assign g_epop  = eng_pop_i && have[eo_lane];
  assign g_r32   = rd32_i && !eng_pop_i && eff_mode == MODE_WORD && (&have);
  assign g_r8    = rd8_i && !eng_pop_i && !rd32_i && eff_mode == MODE_BYTE && have[0];

  assign bad = (wr32_i && !g_w32) || (wr8_i && !g_w8) || (rd32_i && !g_r32) ||
               (rd8_i && !g_r8) || (eng_push_i && !g_epush) || (eng_pop_i && !g_epop);

  assign drain = (|pop_o) && (&nxt_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      mode_q   <= MODE_WORD;
      wl_q     <= '0;
      rl_q     <= '0;
      ill_q    <= 1'b0;
    end else if (soft_rst_i) begin
      locked_q <= 1'b0;
      mode_q   <= MODE_WORD;
      wl_q     <= '0;
      rl_q     <= '0;
      ill_q    <= 1'b0;
    end else begin
      ill_q <= bad;
      if (g_epush && eff_mode == MODE_WORD) wl_q <= nxt(wl_q);
      if (g_epop && eff_mode == MODE_WORD)  rl_q <= nxt(rl_q);
      if (drain) begin
        locked_q <= 1'b0;
        mode_q   <= MODE_WORD;
        wl_q     <= '0;
        rl_q     <= '0;
      end else if (!locked_q && (host_any || eng_push_i)) begin
        locked_q <= 1'b1;
        mode_q   <= eff_mode;
      end
    end
  end

  assign eng_push_ok_o  = g_epush;
  assign host_word_ok_o = g_w32;
  assign pop_lane_o     = eo_lane;
  assign mode_o         = mode_q;
  assign illegal_o      = ill_q;
endmodule

// File: rtl/qlf_flags.sv
module qlf_flags
  import qlf_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int DEPTH    = 16,
  parameter int LOW_MARK = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int FILL_W = $clog2(LANES * DEPTH + 1) + 1
) (
  input  logic [LANES-1:0][CNT_W-1:0] cnt_i,
  input  acc_mode_e                   mode_i,
  output logic                        full_o,
  output logic                        half_o,
  output logic                        empty_o,
  output logic                        low_water_o,
  output logic                        word_avail_o,
  output logic                        byte_avail_o
);
  logic [FILL_W-1:0] fill, cap;
  logic              all_have;

  always_comb begin
    fill     = '0;
    all_have = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      fill     = fill + FILL_W'(cnt_i[l]);
      all_have = all_have && (cnt_i[l] != '0);
    end
  end

  assign cap          = (mode_i == MODE_BYTE) ? FILL_W'(DEPTH) : FILL_W'(LANES * DEPTH);
  assign empty_o      = fill == '0;
  assign full_o       = fill >= cap;
  assign half_o       = (fill << 1) >= cap;
  assign low_water_o  = fill <= FILL_W'(LOW_MARK);
  assign word_avail_o = (mode_i == MODE_WORD) && all_have;
  assign byte_avail_o = (mode_i == MODE_BYTE) && (cnt_i[0] != '0);
endmodule

// File: rtl/quad_lane_fifo.sv
module quad_lane_fifo
  import qlf_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int DEPTH    = 16,
  parameter int BYTE_W   = 8,
  parameter int LOW_MARK = 8,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr32_i,
  input  logic [WORD_W-1:0] wr32_data_i,
  input  logic              wr8_i,
  input  logic [BYTE_W-1:0] wr8_data_i,
  input  logic              rd32_i,
  output logic [WORD_W-1:0] rd32_data_o,
  input  logic              rd8_i,
  output logic [BYTE_W-1:0] rd8_data_o,
  input  logic              eng_push_i,
  input  logic [BYTE_W-1:0] eng_push_data_i,
  input  logic              eng_pop_i,
  output logic [BYTE_W-1:0] eng_pop_data_o,
  output logic              full_o,
  output logic              half_o,
  output logic              empty_o,
  output logic              low_water_o,
  output logic              word_avail_o,
  output logic              byte_avail_o,
  output logic              illegal_o
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0][CNT_W-1:0]  cnt;
  logic [LANES-1:0][BYTE_W-1:0] head;
  logic [LANES-1:0]             push, pop;
  logic                         eng_push_ok, host_word_ok;
  logic [LANE_W-1:0]            pop_lane;
  acc_mode_e                    mode;

  qlf_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .soft_rst_i,
    .wr32_i, .wr8_i, .rd32_i, .rd8_i, .eng_push_i, .eng_pop_i,
    .cnt_i          (cnt),
    .push_o         (push),
    .pop_o          (pop),
    .eng_push_ok_o  (eng_push_ok),
    .host_word_ok_o (host_word_ok),
    .pop_lane_o     (pop_lane),
    .mode_o         (mode),
    .illegal_o      (illegal_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] din;
    assign din = eng_push_ok  ? eng_push_data_i :
                 host_word_ok ? wr32_data_i[l*BYTE_W +: BYTE_W] : wr8_data_i;
    qlf_lane #(.DEPTH(DEPTH), .W(BYTE_W)) u_lane (
      .clk_i, .rst_ni,
      .clr_i  (soft_rst_i),
      .push_i (push[l]),
      .din_i  (din),
      .pop_i  (pop[l]),
      .head_o (head[l]),
      .cnt_o  (cnt[l])
    );
  end

  qlf_flags #(.LANES(LANES), .DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_flags (
    .cnt_i (cnt), .mode_i (mode),
    .full_o, .half_o, .empty_o, .low_water_o, .word_avail_o, .byte_avail_o
  );

  assign rd32_data_o    = head;
  assign rd8_data_o     = head[0];
  assign eng_pop_data_o = head[pop_lane];
endmodule

// File: rtl/qlf_chk.sv
module qlf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic soft_rst_i,
  input logic wr32_i,
  input logic wr8_i,
  input logic rd8_i,
  input logic eng_push_i,
  input logic eng_pop_i,
  input logic full_o,
  input logic empty_o,
  input logic word_avail_o,
  input logic byte_avail_o,
  input logic illegal_o
);
  // R6
  empty_no_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (!word_avail_o && !byte_avail_o));

  // R6
  full_not_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !empty_o);

  // R7
  pop_empty_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_pop_i && empty_o && !soft_rst_i) |=> illegal_o);

  // R7
  read_empty_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd8_i && empty_o && !soft_rst_i) |=> illegal_o);

  // R2
  word_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr32_i && full_o && !eng_push_i && !soft_rst_i) |=> illegal_o);

  // R3
  byte_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr8_i && full_o && !eng_push_i && !soft_rst_i) |=> illegal_o);

  // R9
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (empty_o && !illegal_o));
endmodule

bind quad_lane_fifo qlf_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .soft_rst_i   (soft_rst_i),
  .wr32_i       (wr32_i),
  .wr8_i        (wr8_i),
  .rd8_i        (rd8_i),
  .eng_push_i   (eng_push_i),
  .eng_pop_i    (eng_pop_i),
  .full_o       (full_o),
  .empty_o      (empty_o),
  .word_avail_o (word_avail_o),
  .byte_avail_o (byte_avail_o),
  .illegal_o    (illegal_o)
);

// File: tb/sim_quad_lane_fifo.sv
`timescale 1ns/1ps
module sim_quad_lane_fifo;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        wr32_i = 1'b0, wr8_i = 1'b0, rd32_i = 1'b0, rd8_i = 1'b0;
  logic        eng_push_i = 1'b0, eng_pop_i = 1'b0;
  logic [31:0] wr32_data_i = '0;
  logic [7:0]  wr8_data_i = '0, eng_push_data_i = '0;
  logic [31:0] rd32_data_o;
  logic [7:0]  rd8_data_o, eng_pop_data_o;
  logic        full_o, half_o, empty_o, low_water_o, word_avail_o, byte_avail_o, illegal_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  always #2 clk_i = ~clk_i;

  quad_lane_fifo u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic w32(input logic [31:0] d, input bit keep);
    wr32_i = 1'b1; wr32_data_i = d;
    if (keep) for (int b = 0; b < 4; b++) tx_q.push_back(d[b*8 +: 8]);
    @(negedge clk_i);
    wr32_i = 1'b0;
  endtask

  task automatic w8(input logic [7:0] d, input bit keep);
    wr8_i = 1'b1; wr8_data_i = d;
    if (keep) tx_q.push_back(d);
    @(negedge clk_i);
    wr8_i = 1'b0;
  endtask

  task automatic epop(input string tag);
    logic [7:0] e;
    eng_pop_i = 1'b1;
    #1;
    e = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hxx;
    chk(tag, {24'h0, eng_pop_data_o}, {24'h0, e});
    @(negedge clk_i);
    eng_pop_i = 1'b0;
  endtask

  task automatic epush(input logic [7:0] d);
    eng_push_i = 1'b1; eng_push_data_i = d;
    rx_q.push_back(d);
    @(negedge clk_i);
    eng_push_i = 1'b0;
  endtask

  task automatic r32(input string tag);
    logic [31:0] e;
    for (int b = 0; b < 4; b++) e[b*8 +: 8] = rx_q.pop_front();
    rd32_i = 1'b1;
    #1;
    chk(tag, rd32_data_o, e);
    @(negedge clk_i);
    rd32_i = 1'b0;
  endtask

  task automatic r8(input string tag);
    logic [7:0] e;
    e = rx_q.pop_front();
    rd8_i = 1'b1;
    #1;
    chk(tag, {24'h0, rd8_data_o}, {24'h0, e});
    @(negedge clk_i);
    rd8_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 reset state
    chk("R6 reset empty", empty_o, 1);
    chk("R6 reset full", full_o, 0);
    chk("R6 reset half", half_o, 0);
    chk("R6 reset low", low_water_o, 1);
    chk("R6 reset avail", {word_avail_o, byte_avail_o}, 0);
    chk("R7 reset illegal", illegal_o, 0);

    // R1 lane order on transmit
    w32(32'h44332211, 1); w32(32'h88776655, 1); w32(32'hCCBBAA99, 1);
    for (int i = 0; i < 12; i++) epop("R1 byte order");
    chk("R1 drained", empty_o, 1);

    // R2 / R6 word capacity and flags
    for (int i = 0; i < 16; i++) begin
      w32({8'(i*4+3), 8'(i*4+2), 8'(i*4+1), 8'(i*4)}, 1);
      if (i == 1) chk("R6 low at 8", low_water_o, 1);
      if (i == 2) chk("R6 low off at 12", low_water_o, 0);
      if (i == 6) chk("R6 half off at 28", half_o, 0);
      if (i == 7) chk("R6 half at 32", half_o, 1);
      if (i == 14) chk("R2 not full at 60", full_o, 0);
    end
    chk("R2 full at 64", full_o, 1);
    w32(32'hDEADBEEF, 0);
    chk("R2 overflow illegal", illegal_o, 1);
    chk("R2 still full", full_o, 1);
    for (int i = 0; i < 64; i++) epop("R2 data intact");
    chk("R2 drained", empty_o, 1);

    // R3 byte mode uses lane 0 only
    for (int i = 0; i < 16; i++) begin
      w8(8'hA0 + 8'(i), 1);
      if (i == 7) chk("R6 byte half at 8", half_o, 1);
    end
    chk("R3 full at 16", full_o, 1);
    w8(8'h55, 0);
    chk("R3 overflow illegal", illegal_o, 1);
    for (int i = 0; i < 16; i++) epop("R3 byte order");
    chk("R3 drained", empty_o, 1);

    // R8 width lock
    w8(8'hA1, 1);
    w32(32'h12345678, 0);
    chk("R8 other width illegal", illegal_o, 1);
    epop("R8 byte kept");
    chk("R8 word not stored", empty_o, 1);
    w32(32'h0D0C0B0A, 1);
    chk("R8 unlocked after drain", illegal_o, 0);
    chk("R8 word stored", empty_o, 0);
    for (int i = 0; i < 4; i++) epop("R8 word bytes");

    // R4 receive word mode
    for (int i = 0; i < 3; i++) epush(8'h10 + 8'(i));
    chk("R4 no word at 3", word_avail_o, 0);
    epush(8'h13);
    chk("R4 word at 4", word_avail_o, 1);
    chk("R5 no byte avail in word mode", byte_avail_o, 0);
    epush(8'h14); epush(8'h15);
    r32("R4 first word");
    chk("R4 partial word", word_avail_o, 0);
    epush(8'h16); epush(8'h17);
    r32("R4 second word");
    chk("R4 drained", empty_o, 1);

    // R5 / R7 receive byte mode, locked by a read on empty
    rd8_i = 1'b1; @(negedge clk_i); rd8_i = 1'b0;
    chk("R7 read empty illegal", illegal_o, 1);
    epush(8'h21); epush(8'h22); epush(8'h23);
    chk("R5 byte avail", byte_avail_o, 1);
    chk("R5 no word avail", word_avail_o, 0);
    for (int i = 0; i < 3; i++) r8("R5 byte read order");
    chk("R5 byte avail off", byte_avail_o, 0);

    // R7 pop on empty
    eng_pop_i = 1'b1; @(negedge clk_i); eng_pop_i = 1'b0;
    chk("R7 pop empty illegal", illegal_o, 1);
    chk("R7 still empty", empty_o, 1);

    // R10 engine wins over host write
    eng_push_i = 1'b1; eng_push_data_i = 8'h31; wr32_i = 1'b1; wr32_data_i = 32'hDEADBEEF;
    rx_q.push_back(8'h31);
    @(negedge clk_i);
    eng_push_i = 1'b0; wr32_i = 1'b0;
    chk("R10 host write dropped", illegal_o, 1);
    epush(8'h32); epush(8'h33); epush(8'h34);
    r32("R10 engine bytes only");

    // R9 soft reset mid rotation
    epush(8'h41); epush(8'h42);
    void'(rx_q.pop_front()); void'(rx_q.pop_front());
    soft_rst_i = 1'b1; @(negedge clk_i); soft_rst_i = 1'b0;
    chk("R9 empty after soft reset", empty_o, 1);
    chk("R9 illegal cleared", illegal_o, 0);
    for (int i = 0; i < 4; i++) epush(8'h51 + 8'(i));
    r32("R9 rotation restarts at lane 0");
    w8(8'h77, 1);
    chk("R9 mode unlocked", illegal_o, 0);
    epop("R9 byte after reset");

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule